// File: doc/BRIEF.md
# MSI Interrupt Request Sequencer

This block sits between application logic and the interrupt handshake of a PCIe endpoint core. Application logic raises interrupt events as pulses on a per-vector pending bitmap. The sequencer records those events, raises the function's interrupt status line, and sends the pending vectors to the core one at a time. Each send is a single-cycle request pulse that carries a 5-bit MSI vector number. The sequencer then waits for the core's acknowledge before it sends the next request.

Pending vectors go out lowest index first. Events that arrive while a request is outstanding join the queue, and they are sent before the status line drops. Once the last queued vector has been acknowledged, status falls and the sequence is complete. When MSI is disabled, every request still goes out, but its vector number reads zero. A counter watches each wait for acknowledge and raises a timeout flag if the core takes too long.

Top module: `msi_irq_seq`

## Requirements
- R1: A request on `req_o` is high for exactly one clock cycle.
- R2: At most one request is outstanding. After a request, `req_o` stays low until a cycle in which `ack_i` is high during the wait, and the next request comes no earlier than the cycle after that acknowledge.
- R3: While `req_o` is high, `vec_o` carries the index of the vector being sent if `msi_en_i` is high, and zero if `msi_en_i` is low. When `req_o` is low, `vec_o` is zero.
- R4: `status_o` is high in every cycle in which `req_o` is high. From idle, a bit pulsed on `pend_i` produces the request and the rise of status in the cycle right after the clock edge that sampled it.
- R5: `status_o` stays high from the first request until the acknowledge of the last queued vector. It is low in the cycle after that acknowledge, and it stays low for at least one cycle before a new sequence starts.
- R6: When several bits are pending, they are sent in ascending index order. Index 0 is sent first and index NUM_VEC-1 is sent last.
- R7: A pending bit clears only when its own request is acknowledged. A bit that arrives while a request awaits acknowledge is sent in the same sequence, before status falls, and is sent even if its index is lower than the one in flight.
- R8: `ack_i` has no effect when the block is idle, and no effect in the cycle in which `req_o` is high. Such a pulse neither clears a pending bit nor ends a wait.
- R9: `timeout_o` goes high once ACK_TIMEOUT full cycles have passed in the wait with no acknowledge. It stays high until the acknowledge arrives, and it is low in the cycle after that acknowledge.
- R10: With `msi_en_i` low, each pending bit still produces its own request, and the request count matches the count of pending bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_i | input | NUM_VEC | Interrupt event pulses, one bit per vector |
| msi_en_i | input | 1 | MSI enabled; when low, the vector number is forced to zero |
| ack_i | input | 1 | Acknowledge from the endpoint core for the outstanding request |
| status_o | output | 1 | Function interrupt status, held high while a sequence is active |
| req_o | output | 1 | Single-cycle interrupt request pulse |
| vec_o | output | 5 | MSI vector number, valid with `req_o` |
| timeout_o | output | 1 | Acknowledge overdue |

## Verification
A corrupt pending bitmap shows at the ports within one request: a lost bit appears as a missing request before status falls, and a spurious bit appears as an extra request. A bad vector register shows as a wrong `vec_o` value, or as an out-of-order vector, in the same cycle as the pulse. A state machine stuck in the request state would hold `req_o` high for a second cycle. A state machine stuck in the wait would keep status high after the acknowledge and would raise the timeout flag after ACK_TIMEOUT cycles. Both are seen within a cycle, or within the timeout window, of the fault.

// File: rtl/msi_seq_pkg.sv
// Package: shared constants and the sequencer state type.
// Assumes at most 32 vectors, since the MSI number field is 5 bits wide.
package msi_seq_pkg;
    localparam int unsigned MSI_NUM_W = 5;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_DONE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/msi_pend_track.sv
// Module: pending-vector register.
// Each bit is set by an event pulse and cleared when the request for that
// vector is acknowledged. If a set and a clear hit the same bit in the same
// cycle, the set wins, so no event is lost. pend_nxt_o is the value the
// register takes at the next edge; the sequencer decides from it.
module msi_pend_track
    import msi_seq_pkg::*;
#(
    parameter int unsigned NUM_VEC = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_VEC-1:0]   set_i,
    input  logic                 clr_en_i,
    input  logic [MSI_NUM_W-1:0] clr_idx_i,
    output logic [NUM_VEC-1:0]   pend_nxt_o
);
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] clr_mask;

    // One clear-decode bit per vector.
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_clr
        assign clr_mask[g] = clr_en_i && (clr_idx_i == MSI_NUM_W'(g));
    end

    // Merge the held bits, the clear and the new events.
    always_comb begin
        pend_nxt_o = (pend_q & ~clr_mask) | set_i;
    end

    // Hold the pending bitmap.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt_o;
    end
endmodule

// File: rtl/msi_lowest_pick.sv
// Module: lowest-index selector.
// Reports whether any bit is set and gives the index of the lowest set bit.
// Purely combinational.
module msi_lowest_pick
    import msi_seq_pkg::*;
#(
    parameter int unsigned NUM_VEC = 32
) (
    input  logic [NUM_VEC-1:0]   vec_i,
    output logic                 any_o,
    output logic [MSI_NUM_W-1:0] idx_o
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = MSI_NUM_W'(i);
        end
    end
endmodule

// File: rtl/msi_ack_wdog.sv
// Module: acknowledge timeout counter.
// Counts the cycles in which run_i is high and saturates at LIMIT.
// expired_o is high once LIMIT cycles have been counted, for as long as
// run_i stays high. The counter clears whenever run_i is low.
module msi_ack_wdog #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Count wait cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (cnt_q != LIM_C) cnt_q <= cnt_q + 1'b1;
    end

    // Flag while the wait is still running and the limit has been reached.
    always_comb begin
        expired_o = run_i && (cnt_q == LIM_C);
    end
endmodule

// File: rtl/msi_irq_seq.sv
// Module: MSI interrupt request sequencer (top).
// Sends the pending vectors one at a time as single-cycle requests and waits
// for each acknowledge. Status is held high across the whole sequence.
// Assumes ack_i is meaningful only while a request awaits acknowledge, and
// that NUM_VEC <= 32.
module msi_irq_seq
    import msi_seq_pkg::*;
#(
    parameter int unsigned NUM_VEC     = 32,
    parameter int unsigned ACK_TIMEOUT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_VEC-1:0]   pend_i,
    input  logic                 msi_en_i,
    input  logic                 ack_i,
    output logic                 status_o,
    output logic                 req_o,
    output logic [MSI_NUM_W-1:0] vec_o,
    output logic                 timeout_o
);
    seq_state_e           state_q, state_d;
    logic [MSI_NUM_W-1:0] cur_q, cur_d;
    logic [NUM_VEC-1:0]   pend_nxt;
    logic                 pick_any;
    logic [MSI_NUM_W-1:0] pick_idx;
    logic                 ack_hit;

    // An acknowledge counts only while a request is outstanding.
    assign ack_hit = (state_q == SEQ_WAIT) && ack_i;

    msi_pend_track #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (pend_i),
        .clr_en_i   (ack_hit),
        .clr_idx_i  (cur_q),
        .pend_nxt_o (pend_nxt)
    );

    msi_lowest_pick #(.NUM_VEC(NUM_VEC)) u_pick (
        .vec_i (pend_nxt),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    msi_ack_wdog #(.LIMIT(ACK_TIMEOUT)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == SEQ_WAIT),
        .expired_o (timeout_o)
    );

    // Next state and the vector to send next.
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (pick_any) begin
                    state_d = SEQ_ISSUE;
                    cur_d   = pick_idx;
                end
            end
            SEQ_ISSUE: state_d = SEQ_WAIT;
            SEQ_WAIT: begin
                if (ack_hit) begin
                    if (pick_any) begin
                        state_d = SEQ_ISSUE;
                        cur_d   = pick_idx;
                    end else begin
                        state_d = SEQ_DONE;
                    end
                end
            end
            SEQ_DONE: state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // State and current-vector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    // Handshake outputs, decoded from the state.
    always_comb begin
        status_o = (state_q == SEQ_ISSUE) || (state_q == SEQ_WAIT);
        req_o    = (state_q == SEQ_ISSUE);
        vec_o    = (req_o && msi_en_i) ? cur_q : '0;
    end
endmodule

// File: rtl/msi_irq_seq_chk.sv
// Module: port-level protocol checker for msi_irq_seq, attached by bind.
// Tracks one outstanding request from the request and acknowledge pins.
module msi_irq_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       status_o,
    input logic       req_o,
    input logic [4:0] vec_o,
    input logic       ack_i,
    input logic       msi_en_i,
    input logic       timeout_o
);
    logic outst_q;

    // Set on a request, cleared by a later acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)     outst_q <= 1'b0;
        else if (req_o) outst_q <= 1'b1;
        else if (ack_i) outst_q <= 1'b0;
    end

    // R1
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    // R2
    one_outst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !outst_q);

    // R3
    vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o || !msi_en_i) |-> (vec_o == 5'd0));

    // R4
    status_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> status_o);

    // R5
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> status_o);

    // R5
    status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !req_o) |-> outst_q);

    // R5
    status_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o) |=> !status_o);

    // R9
    tmo_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (outst_q && !req_o));
endmodule

bind msi_irq_seq msi_irq_seq_chk u_chk (.*);

// File: tb/msi_irq_seq_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each. Inputs are driven and outputs
// sampled on falling edges.
module msi_irq_seq_test;
    localparam int unsigned NV  = 32;
    localparam int unsigned TMO = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NV-1:0] pend_i;
    logic          msi_en_i;
    logic          ack_i;
    logic          status_o;
    logic          req_o;
    logic [4:0]    vec_o;
    logic          timeout_o;

    int checks = 0;
    int errors = 0;

    msi_irq_seq #(.NUM_VEC(NV), .ACK_TIMEOUT(TMO)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend_i),
        .msi_en_i  (msi_en_i),
        .ack_i     (ack_i),
        .status_o  (status_o),
        .req_o     (req_o),
        .vec_o     (vec_o),
        .timeout_o (timeout_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_pend(input logic [NV-1:0] m);
        pend_i = m;
        @(negedge clk);
        pend_i = '0;
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    // Wait for a request, check it, hold off the acknowledge for dly cycles, then acknowledge.
    task automatic service(input int exp_vec, input int dly, input string tag);
        int n = 0;
        while (!req_o && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(req_o == 1'b1, {tag, " request seen"}, int'(req_o), 1);
        chk(vec_o == 5'(exp_vec), {tag, " vector"}, int'(vec_o), exp_vec);
        chk(status_o == 1'b1, "R4 status with request", int'(status_o), 1);
        @(negedge clk);
        chk(req_o == 1'b0, "R1 single-cycle request", int'(req_o), 0);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk(!req_o && status_o, "R2 no request before ack", int'(req_o), 0);
        end
        pulse_ack();
    endtask

    task automatic t_reset();
        chk(!status_o && !req_o && vec_o == 0 && !timeout_o, "R5 reset idle",
            int'({status_o, req_o, timeout_o}), 0);
    endtask

    task automatic t_single();
        msi_en_i = 1'b1;
        pulse_pend(NV'(1) << 5);
        chk(req_o == 1'b1, "R4 request latency", int'(req_o), 1);
        service(5, 2, "R3");
        chk(status_o == 1'b0, "R5 status falls after last ack", int'(status_o), 0);
        @(negedge clk);
        chk(!status_o && !req_o, "R5 stays idle", int'(status_o), 0);
    endtask

    task automatic t_order();
        pulse_pend((NV'(1) << 31) | (NV'(1) << 9) | (NV'(1) << 3) | NV'(1));
        service(0, 0, "R6 first");
        chk(status_o == 1'b1, "R5 held between vectors", int'(status_o), 1);
        service(3, 1, "R6 second");
        chk(status_o == 1'b1, "R5 held between vectors", int'(status_o), 1);
        service(9, 3, "R6 third");
        service(31, 0, "R6 top index");
        chk(status_o == 1'b0, "R5 falls after final ack", int'(status_o), 0);
        @(negedge clk);
    endtask

    task automatic t_msi_off();
        int reqs = 0;
        msi_en_i = 1'b0;
        pulse_pend((NV'(1) << 2) | (NV'(1) << 7));
        for (int c = 0; c < 30; c++) begin
            if (req_o) begin
                reqs++;
                chk(vec_o == 5'd0, "R3 vector zero when MSI off", int'(vec_o), 0);
                @(negedge clk);
                pulse_ack();
            end else begin
                @(negedge clk);
            end
        end
        chk(reqs == 2, "R10 one request per bit", reqs, 2);
        chk(status_o == 1'b0, "R5 done with MSI off", int'(status_o), 0);
        msi_en_i = 1'b1;
    endtask

    task automatic t_queue();
        pulse_pend(NV'(1) << 4);
        chk(req_o && vec_o == 5'd4, "R7 first vector", int'(vec_o), 4);
        @(negedge clk);
        pulse_pend(NV'(1));
        chk(!req_o && status_o, "R7 still waiting", int'(req_o), 0);
        pulse_ack();
        chk(req_o && vec_o == 5'd0, "R7 queued vector sent", int'(vec_o), 0);
        chk(status_o == 1'b1, "R7 status held for queued", int'(status_o), 1);
        service(0, 1, "R7 queued");
        chk(status_o == 1'b0, "R7 status falls", int'(status_o), 0);
        @(negedge clk);
    endtask

    task automatic t_stray_ack();
        pulse_ack();
        chk(!status_o && !req_o, "R8 idle ack ignored", int'(status_o), 0);
        pulse_pend((NV'(1) << 2) | (NV'(1) << 5));
        chk(req_o && vec_o == 5'd2, "R8 bit 2 kept", int'(vec_o), 2);
        pulse_ack();
        for (int i = 0; i < 3; i++) begin
            chk(!req_o && status_o, "R8 ack during request ignored", int'(req_o), 0);
            @(negedge clk);
        end
        pulse_ack();
        service(5, 0, "R8 next");
        chk(status_o == 1'b0, "R8 sequence ends", int'(status_o), 0);
        @(negedge clk);
    endtask

    task automatic t_timeout();
        pulse_pend(NV'(1) << 10);
        chk(req_o == 1'b1, "R9 request", int'(req_o), 1);
        repeat (TMO) @(negedge clk);
        chk(timeout_o == 1'b0, "R9 no early timeout", int'(timeout_o), 0);
        @(negedge clk);
        chk(timeout_o == 1'b1, "R9 timeout raised", int'(timeout_o), 1);
        repeat (3) @(negedge clk);
        chk(timeout_o && status_o, "R9 timeout held", int'(timeout_o), 1);
        pulse_ack();
        chk(!timeout_o && !status_o, "R9 cleared by ack", int'(timeout_o), 0);
        @(negedge clk);
    endtask

    initial begin
        rst_n    = 1'b0;
        pend_i   = '0;
        msi_en_i = 1'b1;
        ack_i    = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_order();
        t_msi_off();
        t_queue();
        t_stray_ack();
        t_timeout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule